// File: doc/BRIEF.md
# Selectable-Tap Noise Generator Channel

This block is a pseudorandom noise voice for a sound unit. A 15-bit shift register advances once per step period. Each step shifts the register left by one and inserts a fresh feedback bit at the bottom. That bit is the inverted XOR of register bit 7 and one of eight selectable tap positions. The audible result is a 6-bit sample taken from the lowest register bit: full scale (63) or silence (0).

Software programs the channel through byte writes to five register slots: frequency low byte, frequency high byte, tap select, channel control, and a global stop. The enclosing sound unit supplies a `tick` strobe that marks the system-clock instants the channel counts. A step happens after 40 × (2048 − f) counted ticks, where f is the 11-bit frequency.

Control is a two-state machine. CH_OFF is the silent, frozen state. CH_RUN is the counting, stepping state. Three transitions are named:
- ENABLE, from CH_OFF to CH_RUN: a control write with bit 7 set.
- DISABLE, from CH_RUN to CH_OFF: a control write with bit 7 clear.
- STOP, from CH_RUN to CH_OFF: a stop write with bit 0 set.

A control write with bit 7 set while already in CH_RUN keeps the state in CH_RUN, but still clears the register and restarts the count.

Top module: `noise_channel`

## Requirements
- R1: After reset the channel is in CH_OFF, the shift register holds 0 and `sample_o` is 0.
- R2: Register slot is chosen by `wr_sel`: 0 control, 1 frequency low byte, 2 frequency high byte, 3 tap select, 4 global stop; other codes have no effect. Frequency is {high[2:0], low[7:0]}; high-byte bits 7:3 are ignored.
- R3: On each step the register becomes {reg[13:0], ~(reg[tap] ^ reg[7])}.
- R4: The tap select is field bits 6:4 of a slot-3 write. Codes 0..7 select register bits 14, 10, 13, 4, 8, 6, 9, 11 respectively.
- R5: A control write loads the step counter with 40 × (2048 − f). The first step lands on the edge of the period-th counted tick after that write. Every following step comes one full period later, using the frequency current at reload time.
- R6: Only cycles with `tick` high advance the step counter; with `tick` low no step occurs.
- R7: `sample_o` is 63 when register bit 0 is 1 and the channel is in CH_RUN, otherwise 0.
- R8: Any control write and any tap-select write clear the shift register to 0 on the same edge; a clear takes precedence over a step.
- R9: A control write enters CH_RUN when data bit 7 is 1 and CH_OFF when it is 0.
- R10: A stop write with data bit 0 set moves the channel to CH_OFF, leaving the register frozen; a stop write with bit 0 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register slot select |
| wr_data | input | 8 | Write data byte |
| tick | input | 1 | Counting strobe for the step timer |
| sample_o | output | 6 | Noise sample, 0 or 63 |

## Verification
Every register write takes effect on the clock edge that captures it. A silencing write (disable, stop, or a register clear) therefore shows on `sample_o` right after that edge. After an enabling control write, the first new sample appears right after the period-th counted tick edge. Each later one appears exactly one period further on.

The bench drives all inputs and samples at falling edges, so it always observes the state one half-cycle after the edge of interest. It checks the output one edge before each expected step, where the value must still be the old one. It checks again on the step edge itself, where the value must match its own model of the shift sequence.

// File: rtl/noise_pkg.sv
package noise_pkg;

    // Register slot codes carried on wr_sel
    typedef enum logic [2:0] {
        SEL_CTRL    = 3'd0,
        SEL_FREQ_LO = 3'd1,
        SEL_FREQ_HI = 3'd2,
        SEL_TAP     = 3'd3,
        SEL_STOP    = 3'd4
    } reg_sel_e;

    // Channel control states
    typedef enum logic {
        CH_OFF = 1'b0,
        CH_RUN = 1'b1
    } ch_state_e;

    localparam int ENABLE_BIT = 7;   // control byte: run request
    localparam int STOP_BIT   = 0;   // stop byte: halt request
    localparam int TAP_LSB    = 4;   // tap select field 6:4
    localparam int FIXED_TAP  = 7;   // always-used feedback bit

    // Map the 3-bit tap code to a register bit position
    function automatic logic [3:0] tap_index(input logic [2:0] code);
        logic [3:0] pos;
        unique case (code)
            3'd0: pos = 4'd14;
            3'd1: pos = 4'd10;
            3'd2: pos = 4'd13;
            3'd3: pos = 4'd4;
            3'd4: pos = 4'd8;
            3'd5: pos = 4'd6;
            3'd6: pos = 4'd9;
            3'd7: pos = 4'd11;
        endcase
        return pos;
    endfunction

endpackage

// File: rtl/noise_lfsr.sv
module noise_lfsr
    import noise_pkg::*;
#(
    parameter int LFSR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [2:0]        tap_sel,
    output logic [LFSR_W-1:0] state
);

    localparam int IDX_W = $clog2(LFSR_W);

    logic [IDX_W-1:0]  tap_pos;
    logic              fb_bit;
    logic [LFSR_W-1:0] state_nxt;

    always_comb begin
        tap_pos   = IDX_W'(tap_index(tap_sel));
        fb_bit    = ~(state[tap_pos] ^ state[FIXED_TAP]);
        state_nxt = {state[LFSR_W-2:0], fb_bit};
    end

    // Clear outranks a step landing on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= '0;
        end else if (clear) begin
            state <= '0;
        end else if (step) begin
            state <= state_nxt;
        end
    end

endmodule

// File: rtl/noise_step_timer.sv
module noise_step_timer #(
    parameter int FREQ_W    = 11,
    parameter int STEP_MULT = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              load,
    input  logic [FREQ_W-1:0] freq,
    output logic              step
);

    localparam int FULL_SPAN = 2 ** FREQ_W;
    localparam int CNT_W     = $clog2(STEP_MULT * FULL_SPAN + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] span;
    logic [CNT_W-1:0] period;

    always_comb begin
        span   = CNT_W'(FULL_SPAN) - CNT_W'(freq);
        period = span * CNT_W'(STEP_MULT);
        step   = run && tick && !load && (cnt <= CNT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load || step) begin
            cnt <= period;
        end else if (run && tick) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/noise_ctrl_fsm.sv
module noise_ctrl_fsm
    import noise_pkg::*;
#(
    parameter int FREQ_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [7:0]        wr_data,
    output logic              run,
    output logic              lfsr_clear,
    output logic              cnt_load,
    output logic [FREQ_W-1:0] freq,
    output logic [2:0]        tap_sel
);

    localparam int HI_W = FREQ_W - 8;

    ch_state_e state_q, state_d;
    logic      ctrl_wr, tap_wr, stop_wr;

    always_comb begin
        ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
        tap_wr  = wr_en && (wr_sel == SEL_TAP);
        stop_wr = wr_en && (wr_sel == SEL_STOP) && wr_data[STOP_BIT];
    end

    // Frequency and tap fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq    <= '0;
            tap_sel <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_FREQ_LO) freq[7:0]        <= wr_data;
            if (wr_sel == SEL_FREQ_HI) freq[FREQ_W-1:8] <= wr_data[HI_W-1:0];
            if (wr_sel == SEL_TAP)     tap_sel          <= wr_data[TAP_LSB+2:TAP_LSB];
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // Transitions: ENABLE, DISABLE, STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (ctrl_wr && wr_data[ENABLE_BIT]) state_d = CH_RUN;
            end
            CH_RUN: begin
                if (ctrl_wr && !wr_data[ENABLE_BIT]) state_d = CH_OFF;
                else if (stop_wr)                    state_d = CH_OFF;
            end
        endcase
    end

    // Outputs
    always_comb begin
        run        = (state_q == CH_RUN);
        lfsr_clear = ctrl_wr || tap_wr;
        cnt_load   = ctrl_wr;
    end

endmodule

// File: rtl/noise_channel.sv
module noise_channel
    import noise_pkg::*;
#(
    parameter int FREQ_W    = 11,
    parameter int LFSR_W    = 15,
    parameter int STEP_MULT = 40,
    parameter int SAMPLE_W  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_sel,
    input  logic [7:0]          wr_data,
    input  logic                tick,
    output logic [SAMPLE_W-1:0] sample_o
);

    logic              run;
    logic              lfsr_clear;
    logic              cnt_load;
    logic              step;
    logic [FREQ_W-1:0] freq;
    logic [2:0]        tap_sel;
    logic [LFSR_W-1:0] lfsr_q;

    noise_ctrl_fsm #(.FREQ_W(FREQ_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .run        (run),
        .lfsr_clear (lfsr_clear),
        .cnt_load   (cnt_load),
        .freq       (freq),
        .tap_sel    (tap_sel)
    );

    noise_step_timer #(.FREQ_W(FREQ_W), .STEP_MULT(STEP_MULT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick),
        .load  (cnt_load),
        .freq  (freq),
        .step  (step)
    );

    noise_lfsr #(.LFSR_W(LFSR_W)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (lfsr_clear),
        .step    (step),
        .tap_sel (tap_sel),
        .state   (lfsr_q)
    );

    assign sample_o = {SAMPLE_W{run & lfsr_q[0]}};

endmodule

// File: rtl/noise_channel_chk.sv
module noise_channel_chk #(
    parameter int LFSR_W   = 15,
    parameter int SAMPLE_W = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [2:0]          wr_sel,
    input logic                wr_bit0,
    input logic                tick,
    input logic [SAMPLE_W-1:0] sample_o,
    input logic                run,
    input logic [LFSR_W-1:0]   lfsr
);

    logic past_ok;
    logic clear_evt;
    logic stop_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    always_comb begin
        clear_evt = wr_en && (wr_sel == 3'd0 || wr_sel == 3'd3);
        stop_evt  = wr_en && (wr_sel == 3'd4) && wr_bit0;
    end

    a_r7_two_levels: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_o == '0) || (sample_o == '1));

    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(clear_evt) |-> (lfsr == '0));

    a_r3_shift_form: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(clear_evt) && (lfsr != $past(lfsr))
        |-> (lfsr[LFSR_W-1:1] == $past(lfsr[LFSR_W-2:0])));

    a_r6_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(tick) && !$past(clear_evt) |-> $stable(lfsr));

    a_r10_stop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(stop_evt) |-> (sample_o == '0));

    a_r10_frozen_off: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(run) && !$past(clear_evt) |-> $stable(lfsr));

endmodule

bind noise_channel noise_channel_chk #(.LFSR_W(LFSR_W), .SAMPLE_W(SAMPLE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_bit0  (wr_data[0]),
    .tick     (tick),
    .sample_o (sample_o),
    .run      (run),
    .lfsr     (lfsr_q)
);

// File: tb/noise_channel_bench.sv
`timescale 1ns/1ps
module noise_channel_bench;

    localparam int STEPS = 24;
    localparam int NVEC  = 8;

    // {tap code, freq low byte, freq high byte, expected period}
    localparam logic [35:0] VEC [NVEC] = '{
        {3'd0, 8'hFF, 8'h07, 17'd40},
        {3'd1, 8'hFE, 8'hFF, 17'd80},
        {3'd2, 8'hFF, 8'h0F, 17'd40},
        {3'd3, 8'hFD, 8'h07, 17'd120},
        {3'd4, 8'hFF, 8'h07, 17'd40},
        {3'd5, 8'hFE, 8'h07, 17'd80},
        {3'd6, 8'hFF, 8'hF7, 17'd40},
        {3'd7, 8'hFF, 8'h07, 17'd40}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic       tick = 1'b1;
    logic [5:0] sample_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [14:0] model;

    always #4 clk = ~clk;

    noise_channel u_noise_channel (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .tick     (tick),
        .sample_o (sample_o)
    );

    function automatic logic [14:0] ref_next(input logic [14:0] r, input logic [2:0] t);
        int p;
        case (t)
            3'd0: p = 14;
            3'd1: p = 10;
            3'd2: p = 13;
            3'd3: p = 4;
            3'd4: p = 8;
            3'd5: p = 6;
            3'd6: p = 9;
            default: p = 11;
        endcase
        return {r[13:0], ~(r[p] ^ r[7])};
    endfunction

    function automatic logic [5:0] lvl(input logic b);
        return b ? 6'd63 : 6'd0;
    endfunction

    task automatic expect6(input logic [5:0] exp, input string tag);
        n_cmp++;
        if (sample_o !== exp) begin
            n_bad++;
            $display("FAIL %s: sample got %0d expected %0d", tag, sample_o, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        expect6(6'd0, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        expect6(6'd0, "R1 after reset");

        // Table walk: R2 R3 R4 R5 R7
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0]  t;
            logic [16:0] p;
            t = VEC[v][35:33];
            p = VEC[v][16:0];
            wr(3'd1, VEC[v][32:25]);
            wr(3'd2, VEC[v][24:17]);
            wr(3'd3, {1'b0, t, 4'b0});
            wr(3'd0, 8'h80);
            model = '0;
            for (int s = 0; s < STEPS; s++) begin
                repeat (int'(p) - 1) @(negedge clk);
                expect6(lvl(model[0]), "R5 R2 value held before step");
                @(negedge clk);
                model = ref_next(model, t);
                expect6(lvl(model[0]), "R3 R4 step value");
            end
            wr(3'd0, 8'h00);
            expect6(6'd0, "R9 disable write silences");
        end

        // R10 stop with bit 0 clear is ignored (period 40)
        wr(3'd1, 8'hFF);
        wr(3'd2, 8'h07);
        wr(3'd3, 8'h00);
        wr(3'd0, 8'h80);
        wr(3'd4, 8'h00);
        repeat (38) @(negedge clk);
        expect6(6'd0, "R10 ignored stop, before step");
        @(negedge clk);
        expect6(6'd63, "R10 ignored stop, step still due");

        // R10 stop with bit 0 set silences and stays silent
        wr(3'd4, 8'h01);
        expect6(6'd0, "R10 stop silences");
        repeat (120) @(negedge clk);
        expect6(6'd0, "R10 stays off after stop");

        // R8 tap write clears the register
        wr(3'd0, 8'h80);
        repeat (40) @(negedge clk);
        expect6(6'd63, "R8 running before tap write");
        wr(3'd3, 8'h30);
        expect6(6'd0, "R8 tap write clears");

        // R8 R9 control write while running clears and restarts
        wr(3'd0, 8'h80);
        expect6(6'd0, "R8 control write clears");
        repeat (40) @(negedge clk);
        expect6(6'd63, "R9 restarted step");
        wr(3'd0, 8'h00);
        expect6(6'd0, "R9 disable");

        // R6 only counted ticks advance the timer
        tick = 1'b0;
        wr(3'd0, 8'h80);
        repeat (120) @(negedge clk);
        expect6(6'd0, "R6 no step without tick");
        tick = 1'b1;
        repeat (39) @(negedge clk);
        expect6(6'd0, "R6 one tick short of period");
        @(negedge clk);
        expect6(6'd63, "R6 step on period-th tick");

        finish_run();
    end

endmodule